// File: doc/BRIEF.md
# Sector-Rewrite Flash Array Controller

This block is a synchronous behavioural model of a nonvolatile array that is reprogrammed one sector at a time. A host drives a shared address bus, a write data bus, and three active-low strobes: chip select, write strobe and output gate. Accepted writes collect bytes in a sector-wide staging buffer, in any order. When no further byte arrives within a load window, the controller starts a timed internal program cycle. That cycle replaces the whole sector in one step, with no separate erase. Sector positions that were not loaded during the load period come back as 0xFF.

While the program cycle runs, a `busy` output is high. A read of the last byte loaded returns that byte with bit 7 inverted, so software can poll for completion. After reset, a power-on lockout blocks all programming for a fixed number of clocks. The geometry is set by parameters, in sector-address and offset widths. The load window, the program time and the lockout are clock counts, so they can be scaled down for simulation.

Top module: `sector_flash`

## Requirements
- R1: After reset, `busy` is 0 and every array location reads 0xFF.
- R2: During the first POR_CYC clocks after reset is released, every write strobe is ignored: no program cycle starts and the array is unchanged.
- R3: A byte is accepted on a rising clock edge only when `ce_n`=0, `we_n`=0 and `oe_n`=1. With `oe_n`=0, `ce_n`=1 or `we_n`=1, nothing is loaded.
- R4: Bytes of one sector may be loaded in any offset order. `busy` rises exactly LOAD_WIN clocks after the last accepted byte.
- R5: `busy` stays high for exactly PROG_CYC clocks per program cycle.
- R6: After a program cycle, each loaded offset of the sector reads its loaded value, including bits that go from 0 to 1. Offsets that were not loaded read 0xFF. Other sectors are unchanged.
- R7: During a load period, a strobe whose sector address differs from the first byte's sector is ignored, and that byte is never written.
- R8: While `busy` is high, a read of the last loaded address returns that byte with bit 7 inverted and bits 6:0 unchanged. Other addresses return the array contents from before the cycle.
- R9: Write strobes that arrive while `busy` is high are ignored.
- R10: `rdata` shows the addressed byte only when `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise it is 0x00.
- R11: If one offset is loaded more than once in a load period, the last value loaded is the one programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | SECT_W+OFF_W | Byte address: upper SECT_W bits select the sector, lower OFF_W bits the offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when the read is not enabled |
| busy | output | 1 | High during the internal program cycle |

## Verification
The hardest state to reach from the ports is the short span in which `busy` is high and the staged sector is not yet committed. The polling read, the unchanged old contents and the ignored strobes all have to be observed inside it. The bench counts clock edges from the last accepted strobe, so it knows where the window opens. It then reads the last loaded address and a neighbour, and tries further writes, before the commit edge. Reaching the lockout also takes care: strobes have to be issued in the first few cycles after reset is released, before the power-on counter has expired.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } sf_state_t;
endpackage

// File: rtl/sf_por_lock.sv
module sf_por_lock #(
  parameter int POR_CYC = 16
) (
  input  logic clk,
  input  logic rst_ni,
  output logic por_ok
);
  localparam int CW = $clog2(POR_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ~ok_q;
    cnt_d  = cnt_q + CW'(1);
    ok_d   = (cnt_q == CW'(POR_CYC - 1));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign por_ok = ok_q;
endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import sf_pkg::*;
#(
  parameter int SECT_W   = 3,
  parameter int OFF_W    = 4,
  parameter int LOAD_WIN = 8,
  parameter int PROG_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_ok,
  input  logic [SECT_W-1:0] sect_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [7:0]        din,
  output logic              buf_start,
  output logic              buf_store,
  output logic              commit,
  output logic              busy,
  output logic [SECT_W-1:0] sect_q,
  output logic [OFF_W-1:0]  last_off,
  output logic [7:0]        last_dat
);
  localparam int WW = $clog2(LOAD_WIN + 1);
  localparam int PW = $clog2(PROG_CYC + 1);

  sf_state_t         st_q, st_d;
  logic [WW-1:0]     win_q, win_d;
  logic [PW-1:0]     pc_q, pc_d;
  logic [SECT_W-1:0] sect_d;
  logic [OFF_W-1:0]  loff_q, loff_d;
  logic [7:0]        ldat_q, ldat_d;
  logic              take;

  always_comb begin
    st_d      = st_q;
    win_d     = win_q;
    pc_d      = pc_q;
    sect_d    = sect_q;
    loff_d    = loff_q;
    ldat_d    = ldat_q;
    buf_start = 1'b0;
    buf_store = 1'b0;
    commit    = 1'b0;
    take      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_ok) begin
          st_d      = ST_LOAD;
          sect_d    = sect_in;
          win_d     = '0;
          buf_start = 1'b1;
          take      = 1'b1;
        end
      end
      ST_LOAD: begin
        if (wr_ok && (sect_in == sect_q)) begin
          buf_store = 1'b1;
          win_d     = '0;
          take      = 1'b1;
        end else if (win_q == WW'(LOAD_WIN - 1)) begin
          st_d = ST_PROG;
          pc_d = '0;
        end else begin
          win_d = win_q + WW'(1);
        end
      end
      ST_PROG: begin
        if (pc_q == PW'(PROG_CYC - 1)) begin
          commit = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          pc_d = pc_q + PW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (take) begin
      loff_d = off_in;
      ldat_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      win_q  <= '0;
      pc_q   <= '0;
      sect_q <= '0;
      loff_q <= '0;
      ldat_q <= '0;
    end else begin
      st_q   <= st_d;
      win_q  <= win_d;
      pc_q   <= pc_d;
      sect_q <= sect_d;
      loff_q <= loff_d;
      ldat_q <= ldat_d;
    end
  end

  assign busy     = (st_q == ST_PROG);
  assign last_off = loff_q;
  assign last_dat = ldat_q;
endmodule

// File: rtl/sf_load_buf.sv
module sf_load_buf #(
  parameter int OFF_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       start,
  input  logic                       store,
  input  logic [OFF_W-1:0]           off,
  input  logic [7:0]                 din,
  output logic [(2**OFF_W)*8-1:0]    buf_flat
);
  localparam int SB = 2 ** OFF_W;

  logic [7:0] stage_q [SB];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SB; i++) stage_q[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < SB; i++) begin
        if (start) begin
          stage_q[i] <= (OFF_W'(i) == off) ? din : 8'hFF;
        end else if (store && (OFF_W'(i) == off)) begin
          stage_q[i] <= din;
        end
      end
    end
  end

  for (genvar g = 0; g < SB; g++) begin : g_pack
    assign buf_flat[g*8 +: 8] = stage_q[g];
  end
endmodule

// File: rtl/sf_array.sv
module sf_array #(
  parameter int SECT_W = 3,
  parameter int OFF_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        commit,
  input  logic [SECT_W-1:0]           sect,
  input  logic [(2**OFF_W)*8-1:0]     buf_flat,
  input  logic                        rd_en,
  input  logic [SECT_W+OFF_W-1:0]     raddr,
  input  logic                        poll_en,
  input  logic [SECT_W+OFF_W-1:0]     poll_addr,
  input  logic [7:0]                  poll_dat,
  output logic [7:0]                  rdata
);
  localparam int AW = SECT_W + OFF_W;
  localparam int NB = 2 ** AW;
  localparam int SB = 2 ** OFF_W;

  logic [7:0] mem_q [NB];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < SB; i++) mem_q[{sect, OFF_W'(i)}] <= buf_flat[i*8 +: 8];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (poll_en && (raddr == poll_addr)) rdata = {~poll_dat[7], poll_dat[6:0]};
      else                                 rdata = mem_q[raddr];
    end
  end
endmodule

// File: rtl/sector_flash.sv
module sector_flash #(
  parameter int SECT_W   = 3,
  parameter int OFF_W    = 4,
  parameter int LOAD_WIN = 8,
  parameter int PROG_CYC = 20,
  parameter int POR_CYC  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [SECT_W+OFF_W-1:0] addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    busy
);
  localparam int AW = SECT_W + OFF_W;
  localparam int SB = 2 ** OFF_W;

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic              por_ok;
  logic              wr_stb, wr_ok, rd_en;
  logic              buf_start, buf_store, commit;
  logic [SECT_W-1:0] sect_q;
  logic [OFF_W-1:0]  last_off;
  logic [7:0]        last_dat;
  logic [SB*8-1:0]   buf_flat;

  assign wr_stb = ~ce_n & ~we_n & oe_n;
  assign wr_ok  = wr_stb & por_ok;
  assign rd_en  = ~ce_n & ~oe_n & we_n;

  sf_por_lock #(.POR_CYC(POR_CYC)) u_por (
    .clk    (clk),
    .rst_ni (rst_ni),
    .por_ok (por_ok)
  );

  sf_ctrl #(
    .SECT_W(SECT_W), .OFF_W(OFF_W), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_ok     (wr_ok),
    .sect_in   (addr[AW-1:OFF_W]),
    .off_in    (addr[OFF_W-1:0]),
    .din       (wdata),
    .buf_start (buf_start),
    .buf_store (buf_store),
    .commit    (commit),
    .busy      (busy),
    .sect_q    (sect_q),
    .last_off  (last_off),
    .last_dat  (last_dat)
  );

  sf_load_buf #(.OFF_W(OFF_W)) u_buf (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .start    (buf_start),
    .store    (buf_store),
    .off      (addr[OFF_W-1:0]),
    .din      (wdata),
    .buf_flat (buf_flat)
  );

  sf_array #(.SECT_W(SECT_W), .OFF_W(OFF_W)) u_arr (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .commit    (commit),
    .sect      (sect_q),
    .buf_flat  (buf_flat),
    .rd_en     (rd_en),
    .raddr     (addr),
    .poll_en   (busy),
    .poll_addr ({sect_q, last_off}),
    .poll_dat  (last_dat),
    .rdata     (rdata)
  );
endmodule

// File: rtl/sector_flash_chk.sv
module sector_flash_chk #(
  parameter int PROG_CYC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [7:0] rdata,
  input logic       busy,
  input logic       por_ok
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 32'd1;
    else           busy_run <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 32'(PROG_CYC)));

  // R5, R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 32'(PROG_CYC)));

  // R2
  por_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |-> !busy);

  // R10
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !oe_n && we_n) |-> (rdata == 8'h00));
endmodule

bind sector_flash sector_flash_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce_n   (ce_n),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .rdata  (rdata),
  .busy   (busy),
  .por_ok (por_ok)
);

// File: tb/sector_flash_tb_top.sv
module sector_flash_tb_top;
  localparam int SW  = 3;
  localparam int OW  = 4;
  localparam int LW  = 8;
  localparam int PC  = 20;
  localparam int POR = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we_n, oe_n;
  logic [SW+OW-1:0] addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          busy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  sector_flash #(.SECT_W(SW), .OFF_W(OW), .LOAD_WIN(LW), .PROG_CYC(PC), .POR_CYC(POR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  function automatic logic [SW+OW-1:0] ad(input int s, input int o);
    return {SW'(s), OW'(o)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [SW+OW-1:0] a, input logic [7:0] d,
                       input logic c, input logic w, input logic o);
    @(negedge clk);
    addr = a; wdata = d; ce_n = c; we_n = w; oe_n = o;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [SW+OW-1:0] a, input logic [7:0] d);
    drive(a, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [SW+OW-1:0] a, output logic [7:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 v = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic chk_rd(input int s, input int o, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(ad(s, o), v);
    check(v == exp, req, v, exp);
  endtask

  task automatic finish_prog();
    repeat (LW + PC + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    rst_n = 1'b1;
    chk_rd(0, 0, 8'hFF, "R1 erased");
    chk_rd(7, 15, 8'hFF, "R1 erased");
  endtask

  task automatic t_lockout();
    bit seen = 0;
    wr(ad(0, 5), 8'h12);
    wr(ad(0, 6), 8'h34);
    for (int i = 0; i < LW + PC + 4; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    check(!seen, "R2 no program", seen, 0);
    chk_rd(0, 5, 8'hFF, "R2 unchanged");
    repeat (POR) @(negedge clk);
  endtask

  task automatic t_inhibit();
    bit seen = 0;
    drive(ad(6, 0), 8'h00, 1'b0, 1'b0, 1'b0);
    drive(ad(6, 1), 8'h00, 1'b1, 1'b0, 1'b1);
    drive(ad(6, 2), 8'h00, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < LW + PC + 4; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    check(!seen, "R3 inhibited", seen, 0);
    chk_rd(6, 0, 8'hFF, "R3 unchanged");
  endtask

  task automatic t_load_timing();
    int n;
    wr(ad(1, 9), 8'hA9);
    wr(ad(1, 2), 8'h22);
    wr(ad(1, 15), 8'h5F);
    repeat (LW - 1) @(negedge clk);
    check(busy == 1'b0, "R4 window not yet expired", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R4 busy after window", busy, 1);
    n = 1;
    while (busy && n < 1000) begin
      @(negedge clk);
      if (busy) n++;
    end
    check(n == PC, "R5 busy length", n, PC);
    chk_rd(1, 9, 8'hA9, "R4 any order");
    chk_rd(1, 2, 8'h22, "R4 any order");
    chk_rd(1, 15, 8'h5F, "R4 any order");
    chk_rd(1, 0, 8'hFF, "R6 unloaded FF");
    chk_rd(0, 9, 8'hFF, "R6 other sector");
  endtask

  task automatic t_rewrite();
    wr(ad(1, 2), 8'hF0);
    wr(ad(1, 4), 8'h00);
    finish_prog();
    chk_rd(1, 2, 8'hF0, "R6 zero-to-one rewrite");
    chk_rd(1, 4, 8'h00, "R6 loaded");
    chk_rd(1, 9, 8'hFF, "R6 old byte replaced by FF");
  endtask

  task automatic t_poll();
    wr(ad(2, 3), 8'h35);
    wr(ad(2, 7), 8'hC4);
    repeat (LW + 1) @(negedge clk);
    check(busy == 1'b1, "R8 busy", busy, 1);
    chk_rd(2, 7, 8'h44, "R8 polling bit 7");
    chk_rd(2, 3, 8'hFF, "R8 old content");
    chk_rd(1, 2, 8'hF0, "R8 other sector");
    wr(ad(2, 3), 8'h00);
    wr(ad(3, 0), 8'h55);
    finish_prog();
    check(busy == 1'b0, "R9 cycle not extended", busy, 0);
    chk_rd(2, 7, 8'hC4, "R8 true data after");
    chk_rd(2, 3, 8'h35, "R9 busy write ignored");
    chk_rd(3, 0, 8'hFF, "R9 busy write ignored");
  endtask

  task automatic t_wrong_sector();
    wr(ad(4, 1), 8'h11);
    wr(ad(5, 1), 8'h22);
    finish_prog();
    chk_rd(4, 1, 8'h11, "R7 first sector");
    chk_rd(5, 1, 8'hFF, "R7 other sector ignored");
  endtask

  task automatic t_last_wins();
    wr(ad(7, 5), 8'h01);
    wr(ad(7, 5), 8'h77);
    finish_prog();
    chk_rd(7, 5, 8'h77, "R11 last value");
  endtask

  task automatic t_read_gate();
    @(negedge clk);
    addr = ad(4, 1); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    #1 check(rdata == 8'h00, "R10 oe_n high", rdata, 0);
    ce_n = 1'b1; oe_n = 1'b0;
    #1 check(rdata == 8'h00, "R10 ce_n high", rdata, 0);
    oe_n = 1'b1;
    chk_rd(4, 1, 8'h11, "R10 enabled read");
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_inhibit();
    t_load_timing();
    t_rewrite();
    t_poll();
    t_wrong_sector();
    t_last_wins();
    t_read_gate();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule